// File: doc/BRIEF.md
# Channel Ownership Trace Message Generator

This block watches a multi-channel, event-driven service engine and turns its activity into trace messages. It produces an ownership message whenever a channel service begins or finishes, and a register-write message whenever the engine writes a channel register. It queues both kinds in a small FIFO for a trace port to drain. A 32-bit per-channel enable mask filters both kinds, and each kind also has its own enable.

When the FIFO has no room, the message is dropped and the loss is remembered. One error message, carrying a code for the kind that was lost, then enters the queue ahead of the next message that is accepted. An optional stall mode holds the engine's pipeline once the queue is close to full, and lets it go only after the queue has drained completely. This reduces losses but does not remove them.

Every queued message is a 6-bit type code plus a 26-bit payload. The ownership type is 0x02, the register-write type is 0x3C and the error type is 0x08.

Top module: `own_trace_gen`

## Requirements
- R1: During reset and after it, the queue is empty (`tq_valid` low) and `stall_req` is low.
- R2: When `svc_begin` or `svc_end` is high in a cycle and the message is enabled, one message of type 0x02 is queued at that clock edge. Its payload holds the end flag in bit 0 (1 for end, 0 for begin), the channel number in bits 5:1 and the service ID in bits 8:6, with all other bits zero.
- R3: A message for channel n is produced only when bit n of `chan_trace_mask` is 1. For example, mask 0x00000009 passes channels 0 and 3 only.
- R4: When `crw_wr` is high, `crw_msg_en` is 1 and the channel's mask bit is set, one message of type 0x3C is queued. Its payload holds the channel in bits 4:0, the register index in bits 8:5 and the written data in bits 24:9. With `crw_msg_en` at 0, a register write queues nothing.
- R5: With `own_msg_en` at 0, begin and end events queue nothing.
- R6: A message that finds the FIFO full is dropped. Exactly one type-0x08 message then enters ahead of the next accepted message. Its payload holds the code of the most recent loss: 0 for an ownership message, 1 for a branch message (reserved), 2 for a register-write message. If only one slot is free when an event arrives while an error is pending, the error is queued and the event is lost.
- R7: With `stall_mode_en` at 1, `stall_req` rises one cycle after occupancy reaches DEPTH-2. It falls one cycle after the queue is empty. With `stall_mode_en` at 0, it is low from the following cycle on.
- R8: Messages leave in the order they were queued. The head is popped on a clock edge where `tq_valid` and `tq_ready` are both high, and it holds stable while `tq_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_trace_mask | input | 32 | Per-channel trace enable, bit n for channel n |
| own_msg_en | input | 1 | Enables ownership messages |
| crw_msg_en | input | 1 | Enables register-write messages |
| stall_mode_en | input | 1 | Enables the stall request |
| svc_begin | input | 1 | A channel service starts this cycle |
| svc_end | input | 1 | A channel service ends this cycle |
| svc_chan | input | 5 | Channel being serviced |
| svc_id | input | 3 | Service request ID |
| crw_wr | input | 1 | Channel register write this cycle |
| crw_reg | input | 4 | Index of the written register |
| crw_data | input | 16 | Data written |
| stall_req | output | 1 | Hold request to the engine pipeline |
| tq_valid | output | 1 | Queue head is valid |
| tq_ready | input | 1 | Trace port takes the head |
| tq_type | output | 6 | Head message type code |
| tq_payload | output | 26 | Head message payload |

## Verification
The assertions check on every cycle that:
- the state after reset is empty and unstalled;
- the head holds steady while it is back-pressured;
- only the three legal type codes appear;
- the stall request releases once the queue is empty and stays off when stall mode is off.

Only the bench's scenarios can show the following:
- payload packing and mask filtering;
- the per-kind enables;
- the loss code carried by an inserted error;
- the one-free-slot case, where an error is queued but the event is lost;
- the exact cycle at which the stall request rises at the DEPTH-2 threshold.

A reference queue model is compared on every clock to cover these.

// File: rtl/otm_pkg.sv
package otm_pkg;
    parameter int CHANS  = 32;
    parameter int CHAN_W = $clog2(CHANS);
    parameter int SVC_W  = 3;
    parameter int REG_W  = 4;
    parameter int DAT_W  = 16;
    parameter int TYPE_W = 6;
    parameter int PAY_W  = 26;
    parameter int CODE_W = 4;

    typedef enum logic [TYPE_W-1:0] {
        MT_OWN = 6'h02,
        MT_ERR = 6'h08,
        MT_CRW = 6'h3C
    } msg_kind_e;

    localparam logic [CODE_W-1:0] LOSS_OWN    = 4'd0;
    localparam logic [CODE_W-1:0] LOSS_BRANCH = 4'd1;
    localparam logic [CODE_W-1:0] LOSS_CRW    = 4'd2;

    typedef struct packed {
        msg_kind_e        kind;
        logic [PAY_W-1:0] pay;
    } trace_msg_t;

    function automatic trace_msg_t make_own(input logic fin,
                                            input logic [CHAN_W-1:0] ch,
                                            input logic [SVC_W-1:0] sid);
        trace_msg_t m;
        m.kind = MT_OWN;
        m.pay  = PAY_W'({sid, ch, fin});
        return m;
    endfunction

    function automatic trace_msg_t make_crw(input logic [CHAN_W-1:0] ch,
                                            input logic [REG_W-1:0] rg,
                                            input logic [DAT_W-1:0] dat);
        trace_msg_t m;
        m.kind = MT_CRW;
        m.pay  = PAY_W'({dat, rg, ch});
        return m;
    endfunction

    function automatic trace_msg_t make_err(input logic [CODE_W-1:0] code);
        trace_msg_t m;
        m.kind = MT_ERR;
        m.pay  = PAY_W'(code);
        return m;
    endfunction

    function automatic logic [CODE_W-1:0] loss_code(input msg_kind_e k);
        return (k == MT_CRW) ? LOSS_CRW : LOSS_OWN;
    endfunction
endpackage

// File: rtl/otm_msg_build.sv
module otm_msg_build
    import otm_pkg::*;
(
    input  logic [CHANS-1:0]  mask,
    input  logic              own_en,
    input  logic              crw_en,
    input  logic              begin_evt,
    input  logic              end_evt,
    input  logic [CHAN_W-1:0] chan,
    input  logic [SVC_W-1:0]  sid,
    input  logic              crw_evt,
    input  logic [REG_W-1:0]  rg,
    input  logic [DAT_W-1:0]  dat,
    output logic              cand_valid,
    output trace_msg_t        cand
);
    logic chan_on;
    assign chan_on = mask[chan];

    always_comb begin
        cand_valid = 1'b0;
        cand       = make_crw(chan, rg, dat);
        if (chan_on && own_en && (begin_evt || end_evt)) begin
            cand_valid = 1'b1;
            cand       = make_own(end_evt, chan, sid);
        end else if (chan_on && crw_en && crw_evt) begin
            cand_valid = 1'b1;
        end
    end
endmodule

// File: rtl/otm_merge.sv
module otm_merge
    import otm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cand_valid,
    input  trace_msg_t       cand,
    input  logic [CNT_W-1:0] fill,
    output logic [1:0]       wr_n,
    output trace_msg_t       wd0,
    output trace_msg_t       wd1
);
    logic              err_pend;
    logic [CODE_W-1:0] err_code;
    logic              lose;
    int                free;

    always_comb begin
        free = DEPTH - int'(fill);
        wr_n = 2'd0;
        wd0  = cand;
        wd1  = cand;
        lose = 1'b0;
        if (err_pend) begin
            wd0 = make_err(err_code);
            if (cand_valid) begin
                if (free >= 2)      wr_n = 2'd2;
                else if (free == 1) begin wr_n = 2'd1; lose = 1'b1; end
                else                lose = 1'b1;
            end else if (free >= 1) begin
                wr_n = 2'd1;
            end
        end else if (cand_valid) begin
            if (free >= 1) wr_n = 2'd1;
            else           lose = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pend <= 1'b0;
            err_code <= LOSS_OWN;
        end else if (lose) begin
            err_pend <= 1'b1;
            err_code <= loss_code(cand.kind);
        end else if (err_pend && wr_n != 2'd0) begin
            err_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/otm_fifo.sv
module otm_fifo
    import otm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       wr_n,
    input  trace_msg_t       wd0,
    input  trace_msg_t       wd1,
    input  logic             rd_ready,
    output logic             rd_valid,
    output trace_msg_t       rd_msg,
    output logic [CNT_W-1:0] fill
);
    trace_msg_t       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    assign rd_valid = (fill != '0);
    assign rd_msg   = mem[rptr];
    assign pop      = rd_valid && rd_ready;

    always_ff @(posedge clk) begin
        if (wr_n != 2'd0) mem[wptr] <= wd0;
        if (wr_n == 2'd2) mem[step(wptr, 1)] <= wd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            wptr <= step(wptr, int'(wr_n));
            if (pop) rptr <= step(rptr, 1);
            fill <= fill + CNT_W'(wr_n) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/own_trace_gen.sv
module own_trace_gen
    import otm_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHANS-1:0]  chan_trace_mask,
    input  logic              own_msg_en,
    input  logic              crw_msg_en,
    input  logic              stall_mode_en,
    input  logic              svc_begin,
    input  logic              svc_end,
    input  logic [CHAN_W-1:0] svc_chan,
    input  logic [SVC_W-1:0]  svc_id,
    input  logic              crw_wr,
    input  logic [REG_W-1:0]  crw_reg,
    input  logic [DAT_W-1:0]  crw_data,
    output logic              stall_req,
    output logic              tq_valid,
    input  logic              tq_ready,
    output logic [TYPE_W-1:0] tq_type,
    output logic [PAY_W-1:0]  tq_payload
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             cand_valid;
    trace_msg_t       cand, wd0, wd1, head;
    logic [1:0]       wr_n;
    logic [CNT_W-1:0] fill;
    logic             stall_q;

    otm_msg_build u_build (
        .mask(chan_trace_mask), .own_en(own_msg_en), .crw_en(crw_msg_en),
        .begin_evt(svc_begin), .end_evt(svc_end), .chan(svc_chan), .sid(svc_id),
        .crw_evt(crw_wr), .rg(crw_reg), .dat(crw_data),
        .cand_valid(cand_valid), .cand(cand)
    );

    otm_merge #(.DEPTH(DEPTH)) u_merge (
        .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand(cand),
        .fill(fill), .wr_n(wr_n), .wd0(wd0), .wd1(wd1)
    );

    otm_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wd0(wd0), .wd1(wd1),
        .rd_ready(tq_ready), .rd_valid(tq_valid), .rd_msg(head), .fill(fill)
    );

    always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= stall_mode_en &&
                            ((int'(fill) >= DEPTH - 2) || (stall_q && fill != '0));
    end

    assign stall_req  = stall_q;
    assign tq_type    = head.kind;
    assign tq_payload = head.pay;
endmodule

// File: rtl/otm_chk.sv
module otm_chk (
    input logic       clk,
    input logic       rst,
    input logic       stall_mode_en,
    input logic       stall_req,
    input logic       tq_valid,
    input logic       tq_ready,
    input logic [5:0] tq_type,
    input logic [25:0] tq_payload
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) rst |=> (!tq_valid && !stall_req));

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tq_valid && !tq_ready) |=> (tq_valid && $stable(tq_type) && $stable(tq_payload)));

    // R6
    legal_type_chk: assert property (@(posedge clk) disable iff (rst)
        tq_valid |-> (tq_type == 6'h02 || tq_type == 6'h3C || tq_type == 6'h08));

    // R7
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_req && !tq_valid) |=> !stall_req);

    // R7
    stall_off_chk: assert property (@(posedge clk) disable iff (rst)
        !stall_mode_en |=> !stall_req);
endmodule

bind own_trace_gen otm_chk u_chk (
    .clk(clk), .rst(rst), .stall_mode_en(stall_mode_en), .stall_req(stall_req),
    .tq_valid(tq_valid), .tq_ready(tq_ready), .tq_type(tq_type), .tq_payload(tq_payload)
);

// File: tb/own_trace_gen_test.sv
module own_trace_gen_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mask = '0;
    logic        own_en = 1'b0, crw_en = 1'b0, smode = 1'b0;
    logic        sb = 1'b0, se = 1'b0, cw = 1'b0, rdy = 1'b0;
    logic [4:0]  ch = '0;
    logic [2:0]  sid = '0;
    logic [3:0]  rg = '0;
    logic [15:0] dat = '0;
    logic        stall_req, tq_valid;
    logic [5:0]  tq_type;
    logic [25:0] tq_payload;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    own_trace_gen #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .chan_trace_mask(mask), .own_msg_en(own_en),
        .crw_msg_en(crw_en), .stall_mode_en(smode), .svc_begin(sb), .svc_end(se),
        .svc_chan(ch), .svc_id(sid), .crw_wr(cw), .crw_reg(rg), .crw_data(dat),
        .stall_req(stall_req), .tq_valid(tq_valid), .tq_ready(rdy),
        .tq_type(tq_type), .tq_payload(tq_payload)
    );

    // reference model
    logic [31:0] q[$];
    bit          m_pend, m_stall, m_cv;
    int          m_code, m_lc, m_sz, m_free;
    logic [31:0] m_msg;

    function automatic logic [31:0] own_w(input int fin, input int c, input int s);
        return {6'h02, 26'((s << 6) | (c << 1) | fin)};
    endfunction
    function automatic logic [31:0] crw_w(input int c, input int r, input int d);
        return {6'h3C, 26'((d << 9) | (r << 5) | c)};
    endfunction
    function automatic logic [31:0] err_w(input int code);
        return {6'h08, 26'(code)};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_pend = 0; m_code = 0; m_stall = 0;
        end else begin
            m_sz = q.size();
            m_free = DEPTH - m_sz;
            m_cv = 0; m_lc = 0; m_msg = '0;
            if ((sb || se) && own_en && mask[ch]) begin
                m_cv = 1; m_lc = 0; m_msg = own_w(int'(se), int'(ch), int'(sid));
            end else if (cw && crw_en && mask[ch]) begin
                m_cv = 1; m_lc = 2; m_msg = crw_w(int'(ch), int'(rg), int'(dat));
            end
            m_stall = smode && ((m_sz >= DEPTH - 2) || (m_stall && m_sz != 0));
            if (rdy && m_sz > 0) void'(q.pop_front());
            if (m_pend) begin
                if (m_cv) begin
                    if (m_free >= 2) begin q.push_back(err_w(m_code)); q.push_back(m_msg); m_pend = 0; end
                    else if (m_free == 1) begin q.push_back(err_w(m_code)); m_code = m_lc; end
                    else m_code = m_lc;
                end else if (m_free >= 1) begin
                    q.push_back(err_w(m_code)); m_pend = 0;
                end
            end else if (m_cv) begin
                if (m_free >= 1) q.push_back(m_msg);
                else begin m_pend = 1; m_code = m_lc; end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R8 per-cycle model comparison
    always @(negedge clk) begin
        if (!rst) begin
            check(tq_valid == (q.size() > 0), "R8 valid", 32'(tq_valid), 32'(q.size() > 0));
            check(stall_req == m_stall, "R7 stall", 32'(stall_req), 32'(m_stall));
            if (tq_valid && q.size() > 0)
                check({tq_type, tq_payload} == q[0], "R8 head", {tq_type, tq_payload}, q[0]);
        end
    end

    task automatic fire(input bit b, input bit e, input bit w, input int c, input int s,
                        input int r, input int d);
        @(negedge clk);
        sb = b; se = e; cw = w; ch = 5'(c); sid = 3'(s); rg = 4'(r); dat = 16'(d);
        @(negedge clk);
        sb = 0; se = 0; cw = 0;
    endtask

    task automatic pop_expect(input string req, input logic [31:0] exp);
        check(tq_valid && {tq_type, tq_payload} == exp, req, {tq_type, tq_payload}, exp);
        rdy = 1;
        @(negedge clk);
        rdy = 0;
    endtask

    task automatic expect_empty(input string req);
        check(!tq_valid, req, 32'(tq_valid), 32'd0);
    endtask

    initial begin
        #1000000;
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        check(!tq_valid && !stall_req, "R1 reset", {30'd0, tq_valid, stall_req}, 32'd0);

        // R2, R3: mask 0x9 passes channels 0 and 3
        mask = 32'h0000_0009; own_en = 1;
        fire(1, 0, 0, 0, 5, 0, 0);
        fire(1, 0, 0, 3, 2, 0, 0);
        fire(0, 1, 0, 3, 2, 0, 0);
        fire(1, 0, 0, 1, 1, 0, 0);
        fire(1, 0, 0, 4, 1, 0, 0);
        @(negedge clk);
        pop_expect("R2 begin ch0", own_w(0, 0, 5));
        pop_expect("R3 begin ch3", own_w(0, 3, 2));
        pop_expect("R2 end ch3", own_w(1, 3, 2));
        expect_empty("R3 ch1 ch4 filtered");

        // R4
        fire(0, 0, 1, 0, 0, 7, 16'h1234);
        expect_empty("R4 crw disabled");
        crw_en = 1;
        fire(0, 0, 1, 3, 0, 5, 16'hBEEF);
        fire(0, 0, 1, 1, 0, 5, 16'hBEEF);
        pop_expect("R4 crw ch3", crw_w(3, 5, 16'hBEEF));
        expect_empty("R4 crw ch1 masked");

        // R5
        own_en = 0;
        fire(1, 0, 0, 0, 1, 0, 0);
        fire(0, 1, 0, 3, 1, 0, 0);
        expect_empty("R5 ownership disabled");
        own_en = 1;

        // R6 overflow, stall mode off
        mask = 32'hFFFF_FFFF;
        for (int i = 0; i < DEPTH; i++) fire(1, 0, 0, i, 0, 0, 0);
        fire(1, 0, 0, 8, 0, 0, 0);
        fire(0, 0, 1, 9, 0, 1, 16'h00AA);
        check(!stall_req, "R7 stall off when full", 32'(stall_req), 32'd0);
        pop_expect("R8 order ch0", own_w(0, 0, 0));
        fire(1, 0, 0, 9, 0, 0, 0);
        pop_expect("R8 order ch1", own_w(0, 1, 0));
        pop_expect("R8 order ch2", own_w(0, 2, 0));
        fire(1, 0, 0, 10, 0, 0, 0);
        for (int i = 3; i < DEPTH; i++) pop_expect("R8 order", own_w(0, i, 0));
        pop_expect("R6 error code crw", err_w(2));
        pop_expect("R6 error code own", err_w(0));
        pop_expect("R6 accepted after error", own_w(0, 10, 0));
        expect_empty("R6 single error each");

        // R7 stall
        smode = 1;
        for (int i = 0; i < DEPTH - 2; i++) fire(0, 1, 0, i, 1, 0, 0);
        @(negedge clk);
        check(stall_req, "R7 stall at DEPTH-2", 32'(stall_req), 32'd1);
        for (int i = 0; i < DEPTH - 2; i++) pop_expect("R8 drain", own_w(1, i, 1));
        check(stall_req, "R7 stall held until empty seen", 32'(stall_req), 32'd1);
        @(negedge clk);
        check(!stall_req, "R7 stall released", 32'(stall_req), 32'd0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule